// File: doc/BRIEF.md
# Rotating-Memory Instruction Latency Calculator

This block works out how many idle word-times a rotating main store (drum or disk) must turn through before the next instruction word passes under the read heads, and then enforces that wait. At each load strobe it takes the sector fields of three addresses: the instruction just executed, the next counter value and the operand. It also takes the opcode and a geometry select. Each sector field is turned into a physical sector position through an interlace rule. The block then finds how far ahead the next instruction and the operand lie, and picks either a short wait or a wait that adds one full revolution.

The computed delay is loaded into a down-counter. The ready output stays low while the count runs and rises once the count has expired. The fetch sequencer holds off the next fetch until ready is high. The geometry select chooses between a 64-sector track and a 128-sector track. The store itself and track selection lie outside this block.

Top module: `rot_latency`

## Requirements
- R1: With geom_big_i = 0, a 6-bit sector field i (bits 5:0 of the input) maps to physical position (57 * i) mod 64. Bit 6 of the input is ignored.
- R2: With geom_big_i = 1, a 7-bit sector field with bit 0 = b and bits 6:1 = k maps to physical position 64 * b + ((57 * k) mod 64).
- R3: The next-instruction distance is (phys(next) - phys(current)) mod S, and the operand distance is (phys(operand) - phys(current)) mod S. S is 64 in the small geometry and 128 in the large one.
- R4: Opcodes whose window maximum is 0 ignore the operand. If the next-instruction distance is at least 2, the delay is that distance minus 1. Otherwise it is that distance plus S minus 1.
- R5: For the other opcodes, the delay is the next-instruction distance minus 1 when the operand distance lies in the inclusive range from 2 to the opcode's maximum. Otherwise it is the distance plus S minus 1. The maxima for opcodes 0..15 are 7,7,7,7,7,5,8,6,7,7,0,0,7,7,7,7 in the small geometry and 0,16,16,16,0,58,81,79,0,16,0,0,16,16,16,16 in the large one.
- R6: When the short path is chosen but the next-instruction distance is 0, the delay is S minus 1.
- R7: A load sets remain_o to the computed delay D and drives ready_o low in the following cycle. remain_o then falls by one per cycle. ready_o rises exactly D+1 cycles after the load edge.
- R8: A load always restarts the count, including a load while counting and a load in the cycle the count expires.
- R9: During and after reset, ready_o is 1 and remain_o is 0. While idle, both hold until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word-time clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle strobe that captures the inputs and starts a wait |
| geom_big_i | input | 1 | 0 selects the 64-sector geometry, 1 selects the 128-sector geometry |
| opcode_i | input | 4 | Opcode of the instruction just executed |
| cur_sec_i | input | 7 | Sector field of the executed instruction's address |
| next_sec_i | input | 7 | Sector field of the next counter value |
| opnd_sec_i | input | 7 | Sector field of the operand address |
| remain_o | output | 8 | Word-times still to wait |
| ready_o | output | 1 | High when the next fetch may proceed |

## Verification
The two functions that can meet in one cycle are the expiry of a running count and a new load strobe. The bench loads a short delay of 2 and walks the count down to zero. It then raises a new load in exactly the cycle in which the counter would otherwise clear its busy state. The check passes when ready_o stays low and remain_o holds the new delay after that edge, and when ready_o then rises a full new delay plus one cycle later. A second case reloads in the middle of a long count, and a reset in the middle of a count is checked for an immediate return to the idle state.

// File: rtl/rot_lat_pkg.sv
package rot_lat_pkg;
  localparam int OPC_W   = 4;
  localparam int OPC_NUM = 1 << OPC_W;
  localparam int WIN_MIN = 2;

  typedef enum logic {GEOM_SMALL = 1'b0, GEOM_BIG = 1'b1} geom_e;
  typedef int win_tbl_t [OPC_NUM];

  localparam win_tbl_t WIN_MAX_SMALL = '{7, 7, 7, 7, 7, 5, 8, 6, 7, 7, 0, 0, 7, 7, 7, 7};
  localparam win_tbl_t WIN_MAX_BIG   = '{0, 16, 16, 16, 0, 58, 81, 79, 0, 16, 0, 0, 16, 16, 16, 16};

  function automatic int win_max(geom_e g, logic [OPC_W-1:0] opc);
    return (g == GEOM_BIG) ? WIN_MAX_BIG[opc] : WIN_MAX_SMALL[opc];
  endfunction
endpackage

// File: rtl/rot_sector_map.sv
module rot_sector_map
  import rot_lat_pkg::*;
#(
  parameter int SEC_W  = 6,
  parameter int STRIDE = 57
) (
  input  geom_e            geom_i,
  input  logic [SEC_W:0]   logical_i,
  output logic [SEC_W:0]   phys_o
);
  logic [SEC_W-1:0] idx;
  logic [SEC_W-1:0] prod;
  logic             half;

  always_comb begin
    if (geom_i == GEOM_BIG) begin
      idx  = logical_i[SEC_W:1];
      half = logical_i[0];
    end else begin
      idx  = logical_i[SEC_W-1:0];
      half = 1'b0;
    end
    // product wraps modulo 2**SEC_W by truncation
    prod   = SEC_W'(STRIDE) * idx;
    phys_o = {half, prod};
  end
endmodule

// File: rtl/rot_delay_calc.sv
module rot_delay_calc
  import rot_lat_pkg::*;
#(
  parameter int SEC_W = 6
) (
  input  geom_e                geom_i,
  input  logic [OPC_W-1:0]     opcode_i,
  input  logic [SEC_W:0]       cur_phys_i,
  input  logic [SEC_W:0]       next_phys_i,
  input  logic [SEC_W:0]       opnd_phys_i,
  output logic [SEC_W+1:0]     delay_o
);
  localparam int PHYS_W = SEC_W + 1;
  localparam int CNT_W  = SEC_W + 2;

  logic [PHYS_W-1:0] mask, pc_d, op_d;
  logic [CNT_W-1:0]  pc_x, op_x, nsc_x, wmax_x, wmin_x;
  logic              skip_opnd, hit;

  always_comb begin
    mask   = (geom_i == GEOM_BIG) ? {PHYS_W{1'b1}} : {1'b0, {SEC_W{1'b1}}};
    pc_d   = (next_phys_i - cur_phys_i) & mask;
    op_d   = (opnd_phys_i - cur_phys_i) & mask;
    pc_x   = CNT_W'(pc_d);
    op_x   = CNT_W'(op_d);
    nsc_x  = (geom_i == GEOM_BIG) ? (CNT_W'(1) << PHYS_W) : (CNT_W'(1) << SEC_W);
    wmax_x = CNT_W'(win_max(geom_i, opcode_i));
    wmin_x = CNT_W'(WIN_MIN);
    skip_opnd = (wmax_x == '0);
    if (skip_opnd) hit = (pc_x >= wmin_x);
    else           hit = (op_x >= wmin_x) && (op_x <= wmax_x);
    // short path with zero distance would go negative: take a full turn
    if (hit && (pc_d != '0)) delay_o = pc_x - CNT_W'(1);
    else                     delay_o = pc_x + nsc_x - CNT_W'(1);
  end
endmodule

// File: rtl/rot_wait_counter.sv
module rot_wait_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic [CNT_W-1:0] remain_o,
  output logic             ready_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= delay_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign remain_o = cnt_q;
  assign ready_o  = ~busy_q;

  p_count_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !load_i && remain_o != '0) |=> (remain_o == $past(remain_o) - CNT_W'(1)) && !ready_o);

  p_expire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !load_i && remain_o == '0) |=> ready_o);

  p_load_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !ready_o && (remain_o == $past(delay_i)));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !load_i) |=> ready_o && $stable(remain_o));
endmodule

// File: rtl/rot_latency.sv
module rot_latency
  import rot_lat_pkg::*;
#(
  parameter int SEC_W  = 6,
  parameter int STRIDE = 57
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               geom_big_i,
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [SEC_W:0]     cur_sec_i,
  input  logic [SEC_W:0]     next_sec_i,
  input  logic [SEC_W:0]     opnd_sec_i,
  output logic [SEC_W+1:0]   remain_o,
  output logic               ready_o
);
  localparam int PHYS_W  = SEC_W + 1;
  localparam int CNT_W   = SEC_W + 2;
  localparam int N_PORTS = 3;

  geom_e             geom;
  logic [PHYS_W-1:0] log_sec  [N_PORTS];
  logic [PHYS_W-1:0] phys_sec [N_PORTS];
  logic [CNT_W-1:0]  delay;

  assign geom       = geom_e'(geom_big_i);
  assign log_sec[0] = cur_sec_i;
  assign log_sec[1] = next_sec_i;
  assign log_sec[2] = opnd_sec_i;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_map
    rot_sector_map #(.SEC_W(SEC_W), .STRIDE(STRIDE)) u_map (
      .geom_i    (geom),
      .logical_i (log_sec[g]),
      .phys_o    (phys_sec[g])
    );
  end

  rot_delay_calc #(.SEC_W(SEC_W)) u_calc (
    .geom_i      (geom),
    .opcode_i    (opcode_i),
    .cur_phys_i  (phys_sec[0]),
    .next_phys_i (phys_sec[1]),
    .opnd_phys_i (phys_sec[2]),
    .delay_o     (delay)
  );

  rot_wait_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .delay_i  (delay),
    .remain_o (remain_o),
    .ready_o  (ready_o)
  );

  // small track: at most one distance below a revolution plus a revolution
  p_small_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !geom_big_i) |=> remain_o <= CNT_W'((2 << SEC_W) - 2));

  // small track: bit 6 of each field is ignored
  p_small_top_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !geom_big_i |-> phys_sec[0][SEC_W] == 1'b0 && phys_sec[1][SEC_W] == 1'b0);
endmodule

// File: tb/rot_latency_bench.sv
`timescale 1ns/1ps
module rot_latency_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic       big = 1'b0;
  logic [3:0] opc = '0;
  logic [6:0] cur = '0, nxt = '0, opd = '0;
  logic [7:0] remain;
  logic       ready;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  rot_latency u_rot_latency (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .geom_big_i(big),
    .opcode_i(opc), .cur_sec_i(cur), .next_sec_i(nxt), .opnd_sec_i(opd),
    .remain_o(remain), .ready_o(ready)
  );

  typedef struct packed {
    logic       big;
    logic [3:0] opc;
    logic [6:0] cur;
    logic [6:0] nxt;
    logic [6:0] opd;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b0, 4'h1, 7'd0,  7'd1,  7'd9,  8'd120}, // R1 R5 operand out of window
    '{1'b0, 4'h1, 7'd0,  7'd9,  7'd18, 8'd0},   // R1 R5 lower window edge
    '{1'b0, 4'h1, 7'd0,  7'd27, 7'd63, 8'd2},   // R5 upper edge (7)
    '{1'b0, 4'h5, 7'd0,  7'd27, 7'd63, 8'd66},  // R5 max 5 exceeded
    '{1'b0, 4'h6, 7'd0,  7'd27, 7'd63, 8'd2},   // R5 max 8
    '{1'b0, 4'hA, 7'd0,  7'd9,  7'd0,  8'd64},  // R4 distance 1
    '{1'b0, 4'hA, 7'd0,  7'd18, 7'd9,  8'd1},   // R4 operand ignored
    '{1'b0, 4'h7, 7'd9,  7'd0,  7'd63, 8'd62},  // R3 wrap, R5 max 6
    '{1'b0, 4'h1, 7'd5,  7'd5,  7'd23, 8'd63},  // R6 small
    '{1'b1, 4'h1, 7'd0,  7'd18, 7'd36, 8'd0},   // R2 R5
    '{1'b1, 4'h1, 7'd0,  7'd1,  7'd3,  8'd191}, // R2 odd sectors
    '{1'b1, 4'h6, 7'd0,  7'd1,  7'd1,  8'd63},  // R2 R5 max 81
    '{1'b1, 4'h0, 7'd2,  7'd0,  7'd0,  8'd70},  // R3 R4 large wrap
    '{1'b1, 4'h4, 7'd0,  7'd18, 7'd0,  8'd128}, // R4 large full turn
    '{1'b1, 4'h1, 7'd19, 7'd19, 7'd55, 8'd127}, // R6 large
    '{1'b1, 4'h5, 7'd3,  7'd2,  7'd0,  8'd63}   // R3 R5 large wrap
  };

  localparam int MX_S [16] = '{7, 7, 7, 7, 7, 5, 8, 6, 7, 7, 0, 0, 7, 7, 7, 7};
  localparam int MX_B [16] = '{0, 16, 16, 16, 0, 58, 81, 79, 0, 16, 0, 0, 16, 16, 16, 16};

  function automatic int phys(bit b, int a);
    if (!b) return (57 * (a % 64)) % 64;
    return (a % 2) * 64 + (57 * ((a % 128) / 2)) % 64;
  endfunction

  function automatic int ref_delay(bit b, int op, int c, int n, int o);
    int s  = b ? 128 : 64;
    int pd = (phys(b, n) - phys(b, c) + s) % s;
    int od = (phys(b, o) - phys(b, c) + s) % s;
    int mx = b ? MX_B[op] : MX_S[op];
    bit h  = (mx == 0) ? (pd >= 2) : (od >= 2 && od <= mx);
    return (h && pd > 0) ? pd - 1 : pd + s - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic b, input logic [3:0] o, input logic [6:0] c,
                       input logic [6:0] n, input logic [6:0] p);
    big = b; opc = o; cur = c; nxt = n; opd = p; load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_case(input logic b, input logic [3:0] o, input logic [6:0] c,
                          input logic [6:0] n, input logic [6:0] p, input int d, input string req);
    int k = 0;
    apply(b, o, c, n, p);
    chk(remain == 8'(d) && !ready, req, int'(remain), d);
    while (!ready && k < 300) begin
      @(negedge clk);
      k++;
      if (k == 1 && d >= 1) chk(remain == 8'(d - 1), "R7 decrement", int'(remain), d - 1);
    end
    chk(k == d + 1, "R7 ready timing", k, d + 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf = 32'hACE1_1234;
    @(negedge clk); @(negedge clk);
    chk(ready == 1'b1 && remain == 8'd0, "R9 in reset", int'(remain), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(ready == 1'b1 && remain == 8'd0, "R9 idle after reset", int'(ready), 1);

    for (int i = 0; i < 16; i++)
      run_case(VECS[i].big, VECS[i].opc, VECS[i].cur, VECS[i].nxt, VECS[i].opd,
               int'(VECS[i].exp), "R1 R2 R3 R4 R5 R6 table vector");

    // model-driven cases across opcodes and both geometries (R1..R6)
    for (int i = 0; i < 30; i++) begin
      int d;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      d = ref_delay(lf[0], int'(lf[4:1]), int'(lf[11:5]), int'(lf[18:12]), int'(lf[25:19]));
      run_case(lf[0], lf[4:1], lf[11:5], lf[18:12], lf[25:19], d, "R4 R5 model case");
    end

    // R9: idle holds
    repeat (5) @(negedge clk);
    chk(ready == 1'b1 && remain == 8'd0, "R9 idle hold", int'(remain), 0);

    // R8: reload in the middle of a long count
    apply(1'b0, 4'h1, 7'd0, 7'd1, 7'd9);
    repeat (10) @(negedge clk);
    chk(remain == 8'd110 && !ready, "R8 mid count", int'(remain), 110);
    apply(1'b0, 4'h1, 7'd0, 7'd9, 7'd18);
    chk(remain == 8'd0 && !ready, "R8 reload value", int'(remain), 0);
    @(negedge clk);
    chk(ready == 1'b1, "R8 reload expiry", int'(ready), 1);

    // R8: load in the cycle the count expires
    apply(1'b0, 4'h1, 7'd0, 7'd27, 7'd63);
    @(negedge clk); @(negedge clk);
    chk(remain == 8'd0 && !ready, "R8 at zero", int'(remain), 0);
    run_case(1'b0, 4'h5, 7'd0, 7'd27, 7'd63, 66, "R8 load on expiry");

    // R9: reset in the middle of a count
    apply(1'b1, 4'h1, 7'd0, 7'd1, 7'd3);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(ready == 1'b1 && remain == 8'd0, "R9 reset mid count", int'(remain), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R9 after reset release", int'(ready), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule